// File: doc/BRIEF.md
# Low-Power CPU Clock Mode Controller

This block decides which clock the CPU runs from and when the main oscillator is powered. It has five modes: running from the main clock, running from a sub clock, halted, deep sleep with the main oscillator off, and waiting for the main oscillator to stabilize. Software uses two write strobes. One carries an oscillator-off bit. The other carries a two-bit divider select and a bit that picks the sub-clock source, either the 200 kHz ring oscillator or the 32 kHz crystal. Software also raises halt and sleep requests, and an interrupt line wakes the block.

The oscillators and the glitch-free clock switch sit outside the block. It drives an enable for the main oscillator, a flag that says the CPU is on the sub clock, the divider and source selects, and a ready flag for the CPU clock. The stabilization wait is a counter clocked by a sub-clock tick enable, and its length comes in on a port. When the block wakes from deep sleep, the oscillator-off bit as it stood before sleep decides the target. If it is 0, the block restarts the main oscillator, waits, and selects the main clock with the divider cleared. If it is 1, the block returns straight to the sub clock and leaves the divider alone.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset, mode is 0 and the main oscillator enable is 1. The CPU clock ready flag is 1. The sub-clock flag, oscillator-off bit, divider select and source select are all 0.
- R2: While mode is 3 (deep sleep), the main oscillator enable is 0 and the CPU clock ready flag is 0.
- R3: Take a wake from deep sleep when the oscillator-off bit is 0. The block enters mode 4 (stabilizing) with the main oscillator enabled and the CPU clock ready flag at 0. It then moves to mode 0 with the sub-clock flag at 0 and the divider select at 00.
- R4: Take a wake from deep sleep when the oscillator-off bit is 1. On the next clock the block is in mode 1 (sub clock) with the sub-clock flag at 1 and the main oscillator enable at 0. The divider select keeps its value.
- R5: In mode 0 or 1, a clock-control write loads the divider select and the source select. Source select 0 means the ring oscillator and 1 means the crystal.
- R6: Mode 2 (halt) is left on a wake interrupt, back to the mode it was entered from. The divider, source, oscillator-off and sub-clock flag are exactly as they were before the halt. Writes made during halt have no effect. The main oscillator enable keeps its pre-halt value.
- R7: In mode 1, writing the oscillator-off bit as 0 enters mode 4 with the main oscillator enabled. When the wait ends, the block enters mode 0 with the divider select unchanged.
- R8: In mode 0, writing the oscillator-off bit as 1 enters mode 1. The main oscillator enable goes to 0 and the sub-clock flag goes to 1.
- R9: In mode 4, clock-control writes, power-mode writes, halt requests and sleep requests are ignored.
- R10: A wake interrupt during mode 4 does not shorten the wait. The CPU wake output pulses high for exactly one cycle on each wake: on leaving halt, on a wake from deep sleep into mode 1, and on leaving mode 4 after a wake from deep sleep or an interrupt received during mode 4.
- R11: Mode 4 lasts until the block has seen as many high sub-clock ticks as the stabilization length. The tick seen on the final mode-4 cycle is included in that count. A length of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | One-cycle enable per sub-clock period |
| stab_len | input | STAB_W | Stabilization length in sub-clock ticks |
| pm_wr | input | 1 | Power-mode write strobe |
| pm_osc_off | input | 1 | Oscillator-off value written with pm_wr |
| cc_wr | input | 1 | Clock-control write strobe |
| cc_div | input | 2 | Divider select written with cc_wr |
| cc_sub_xtal | input | 1 | Sub-clock source written with cc_wr (1 = crystal) |
| halt_req | input | 1 | Request to enter halt |
| sleep_req | input | 1 | Request to enter deep sleep |
| wake_irq | input | 1 | Wake interrupt |
| main_osc_en | output | 1 | Main oscillator enable |
| clk_on_sub | output | 1 | CPU clock taken from the sub clock |
| div_sel | output | 2 | Current divider select |
| sub_xtal | output | 1 | Current sub-clock source (1 = crystal) |
| osc_off | output | 1 | Current oscillator-off bit |
| cpu_clk_ready | output | 1 | CPU clock running and usable |
| cpu_wake | output | 1 | One-cycle pulse when the CPU resumes |
| mode | output | 3 | 0 main, 1 sub, 2 halt, 3 sleep, 4 stabilizing |

## Verification
The assertions hold on every cycle for these mode invariants: the oscillator is off in sleep and on the sub clock, the ready flag is low while stabilizing, settings stay frozen through halt and stabilization, a wake into mode 1 keeps the divider, and cpu_wake is always a single-cycle pulse. Some behaviour only the directed scenarios can show. These are the stabilization length measured in ticks under different tick spacings, the zero-length case, the divider clearing after a wake to the main clock, and the return target after halt. They also cover the split between a software switch back to the main clock and a wake that lands there.

// File: rtl/lpclk_pkg.sv
// Package: shared mode encoding for the low-power clock controller.
// Assumes: the encoding is visible at the top-level mode port.
package lpclk_pkg;
    typedef enum logic [2:0] {
        ST_RUN_MAIN = 3'd0,
        ST_RUN_SUB  = 3'd1,
        ST_HALT     = 3'd2,
        ST_SLEEP    = 3'd3,
        ST_OSC_STAB = 3'd4
    } lp_mode_e;

    localparam int DIV_W = 2;
endpackage

// File: rtl/lpclk_stab_timer.sv
// Module: counts sub-clock ticks while stabilization is active and flags
// the tick that completes the programmed length.
// Assumes: run is held for the whole wait; a limit of 0 behaves as 1.
module lpclk_stab_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] cnt_next;

    // Purpose: value the count would take after the current tick.
    always_comb begin
        cnt_next = {1'b0, cnt} + EXT_W'(1);
        done     = run && tick && (cnt_next >= {1'b0, limit});
    end

    // Purpose: advance on ticks during the wait, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick && !done) begin
            cnt <= cnt_next[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/lpclk_cfg_regs.sv
// Module: software-visible clock settings (oscillator-off, divider select,
// sub-clock source) with write gating and a forced divider clear.
// Assumes: wr_open is high only in the two run modes.
module lpclk_cfg_regs
    import lpclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_open,
    input  logic             pm_wr,
    input  logic             pm_val,
    input  logic             cc_wr,
    input  logic [DIV_W-1:0] cc_div,
    input  logic             cc_xtal,
    input  logic             force_div0,
    output logic             osc_off,
    output logic [DIV_W-1:0] div_sel,
    output logic             sub_xtal
);
    // Purpose: oscillator-off bit, writable only while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_off <= 1'b0;
        end else if (wr_open && pm_wr) begin
            osc_off <= pm_val;
        end
    end

    // Purpose: divider and source selects; a forced clear wins over writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sel  <= '0;
            sub_xtal <= 1'b0;
        end else if (force_div0) begin
            div_sel  <= '0;
        end else if (wr_open && cc_wr) begin
            div_sel  <= cc_div;
            sub_xtal <= cc_xtal;
        end
    end
endmodule

// File: rtl/lpclk_mode_fsm.sv
// Module: mode sequencer for run, halt, deep sleep and oscillator
// stabilization; owns the sub-clock flag, the wake pulse and the
// main oscillator enable.
// Assumes: osc_off comes from the settings register and is frozen outside
// the run modes; stab_done only pulses while stab_run is high.
module lpclk_mode_fsm
    import lpclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     osc_off,
    input  logic     pm_wr,
    input  logic     pm_val,
    input  logic     halt_req,
    input  logic     sleep_req,
    input  logic     wake_irq,
    input  logic     stab_done,
    output lp_mode_e state,
    output logic     stab_run,
    output logic     cfg_open,
    output logic     force_div0,
    output logic     clk_on_sub,
    output logic     main_osc_en,
    output logic     cpu_ready,
    output logic     cpu_wake
);
    lp_mode_e nxt;
    logic     halt_from_sub;
    logic     from_wake;
    logic     irq_pend;
    logic     wake_now;

    // Purpose: decode mode-level control outputs.
    always_comb begin
        cfg_open    = (state == ST_RUN_MAIN) || (state == ST_RUN_SUB);
        stab_run    = (state == ST_OSC_STAB);
        cpu_ready   = cfg_open;
        main_osc_en = (state == ST_RUN_MAIN) || (state == ST_OSC_STAB) ||
                      ((state == ST_HALT) && !halt_from_sub);
        force_div0  = stab_run && stab_done && from_wake;
    end

    // Purpose: next-mode selection; sleep beats halt beats an oscillator write.
    always_comb begin
        nxt      = state;
        wake_now = 1'b0;
        case (state)
            ST_RUN_MAIN: begin
                if (sleep_req)               nxt = ST_SLEEP;
                else if (halt_req)           nxt = ST_HALT;
                else if (pm_wr && pm_val)    nxt = ST_RUN_SUB;
            end
            ST_RUN_SUB: begin
                if (sleep_req)               nxt = ST_SLEEP;
                else if (halt_req)           nxt = ST_HALT;
                else if (pm_wr && !pm_val)   nxt = ST_OSC_STAB;
            end
            ST_HALT: begin
                if (wake_irq) begin
                    nxt      = halt_from_sub ? ST_RUN_SUB : ST_RUN_MAIN;
                    wake_now = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake_irq) begin
                    nxt      = osc_off ? ST_RUN_SUB : ST_OSC_STAB;
                    wake_now = osc_off;
                end
            end
            ST_OSC_STAB: begin
                if (stab_done) begin
                    nxt      = ST_RUN_MAIN;
                    wake_now = irq_pend || wake_irq;
                end
            end
            default: nxt = ST_RUN_MAIN;
        endcase
    end

    // Purpose: mode register and the flags that travel with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_RUN_MAIN;
            halt_from_sub <= 1'b0;
            from_wake     <= 1'b0;
            irq_pend      <= 1'b0;
            clk_on_sub    <= 1'b0;
            cpu_wake      <= 1'b0;
        end else begin
            state    <= nxt;
            cpu_wake <= wake_now;
            if (nxt == ST_HALT && state != ST_HALT) begin
                halt_from_sub <= (state == ST_RUN_SUB);
            end
            if (nxt == ST_OSC_STAB && state != ST_OSC_STAB) begin
                from_wake <= (state == ST_SLEEP);
                irq_pend  <= (state == ST_SLEEP);
            end else if (state == ST_OSC_STAB && wake_irq) begin
                irq_pend  <= 1'b1;
            end
            if (nxt == ST_RUN_SUB) begin
                clk_on_sub <= 1'b1;
            end else if (nxt == ST_RUN_MAIN && state == ST_OSC_STAB) begin
                clk_on_sub <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lpclk_ctrl.sv
// Module: top of the low-power clock mode controller. Joins the settings
// registers, the mode sequencer and the stabilization timer.
// Assumes: sub_tick is a single-cycle enable in the clk domain; stab_len
// is held steady during a wait.
module lpclk_ctrl
    import lpclk_pkg::*;
#(
    parameter int STAB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_tick,
    input  logic [STAB_W-1:0] stab_len,
    input  logic              pm_wr,
    input  logic              pm_osc_off,
    input  logic              cc_wr,
    input  logic [1:0]        cc_div,
    input  logic              cc_sub_xtal,
    input  logic              halt_req,
    input  logic              sleep_req,
    input  logic              wake_irq,
    output logic              main_osc_en,
    output logic              clk_on_sub,
    output logic [1:0]        div_sel,
    output logic              sub_xtal,
    output logic              osc_off,
    output logic              cpu_clk_ready,
    output logic              cpu_wake,
    output logic [2:0]        mode
);
    lp_mode_e state;
    logic     stab_run;
    logic     stab_done;
    logic     cfg_open;
    logic     force_div0;

    lpclk_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_off     (osc_off),
        .pm_wr       (pm_wr),
        .pm_val      (pm_osc_off),
        .halt_req    (halt_req),
        .sleep_req   (sleep_req),
        .wake_irq    (wake_irq),
        .stab_done   (stab_done),
        .state       (state),
        .stab_run    (stab_run),
        .cfg_open    (cfg_open),
        .force_div0  (force_div0),
        .clk_on_sub  (clk_on_sub),
        .main_osc_en (main_osc_en),
        .cpu_ready   (cpu_clk_ready),
        .cpu_wake    (cpu_wake)
    );

    lpclk_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_open    (cfg_open),
        .pm_wr      (pm_wr),
        .pm_val     (pm_osc_off),
        .cc_wr      (cc_wr),
        .cc_div     (cc_div),
        .cc_xtal    (cc_sub_xtal),
        .force_div0 (force_div0),
        .osc_off    (osc_off),
        .div_sel    (div_sel),
        .sub_xtal   (sub_xtal)
    );

    lpclk_stab_timer #(.CNT_W(STAB_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (stab_run),
        .tick  (sub_tick),
        .limit (stab_len),
        .done  (stab_done)
    );

    // Purpose: expose the mode encoding at the port.
    assign mode = state;
endmodule

// File: rtl/lpclk_ctrl_chk.sv
// Module: cycle-level property checker bound to lpclk_ctrl.
// Assumes: mode uses the package encoding (0 main, 1 sub, 2 halt,
// 3 sleep, 4 stabilizing).
module lpclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       main_osc_en,
    input logic       clk_on_sub,
    input logic [1:0] div_sel,
    input logic       sub_xtal,
    input logic       osc_off,
    input logic       cpu_clk_ready,
    input logic       cpu_wake
);
    AST_SLEEP_OSC_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (!main_osc_en && !cpu_clk_ready)); // R2

    AST_STAB_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4) |-> (main_osc_en && !cpu_clk_ready)); // R3

    AST_WAKE_SUB_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode) == 3'd3) && (mode == 3'd1)) |->
        (clk_on_sub && !main_osc_en && (div_sel == $past(div_sel)))); // R4

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |=> ($stable(div_sel) && $stable(sub_xtal) &&
                            $stable(osc_off) && $stable(clk_on_sub))); // R6

    AST_SUB_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> (!main_osc_en && clk_on_sub)); // R8

    AST_STAB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd4) && ($past(mode) == 3'd4)) |->
        ($stable(sub_xtal) && $stable(osc_off))); // R9

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wake |=> !cpu_wake); // R10
endmodule

bind lpclk_ctrl lpclk_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (mode),
    .main_osc_en   (main_osc_en),
    .clk_on_sub    (clk_on_sub),
    .div_sel       (div_sel),
    .sub_xtal      (sub_xtal),
    .osc_off       (osc_off),
    .cpu_clk_ready (cpu_clk_ready),
    .cpu_wake      (cpu_wake)
);

// File: tb/lpclk_ctrl_tb.sv
// Directed bench for lpclk_ctrl: one task per scenario, each checking
// its own results at the falling edge.
module lpclk_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_tick = 1'b0;
    logic [15:0] stab_len = 16'd5;
    logic        pm_wr = 1'b0, pm_osc_off = 1'b0;
    logic        cc_wr = 1'b0, cc_sub_xtal = 1'b0;
    logic [1:0]  cc_div = 2'b00;
    logic        halt_req = 1'b0, sleep_req = 1'b0, wake_irq = 1'b0;
    logic        main_osc_en, clk_on_sub, sub_xtal, osc_off;
    logic        cpu_clk_ready, cpu_wake;
    logic [1:0]  div_sel;
    logic [2:0]  mode;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_period = 1;
    int tick_ph = 0;
    bit done_flag = 0;

    lpclk_ctrl #(.STAB_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .stab_len(stab_len),
        .pm_wr(pm_wr), .pm_osc_off(pm_osc_off), .cc_wr(cc_wr),
        .cc_div(cc_div), .cc_sub_xtal(cc_sub_xtal), .halt_req(halt_req),
        .sleep_req(sleep_req), .wake_irq(wake_irq),
        .main_osc_en(main_osc_en), .clk_on_sub(clk_on_sub),
        .div_sel(div_sel), .sub_xtal(sub_xtal), .osc_off(osc_off),
        .cpu_clk_ready(cpu_clk_ready), .cpu_wake(cpu_wake), .mode(mode)
    );

    always #4 clk = ~clk;

    // Sub-clock tick: one high cycle per tick_period, changed after the rising edge.
    always @(posedge clk) begin
        #2;
        tick_ph  = (tick_ph + 1 >= tick_period) ? 0 : tick_ph + 1;
        sub_tick = (tick_ph == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One rising edge with the given strobes held, then released.
    task automatic pulse_in(input bit pw, input bit pv, input bit cw,
                            input logic [1:0] cd, input bit cx,
                            input bit hr, input bit sr, input bit wk);
        @(negedge clk);
        pm_wr = pw; pm_osc_off = pv; cc_wr = cw; cc_div = cd; cc_sub_xtal = cx;
        halt_req = hr; sleep_req = sr; wake_irq = wk;
        @(negedge clk);
        pm_wr = 0; cc_wr = 0; halt_req = 0; sleep_req = 0; wake_irq = 0;
    endtask

    // Count mode-4 cycles and ticks seen; inj 1 = writes/requests, 2 = wake irq.
    task automatic measure_stab(input int inj, output int cyc, output int ticks);
        cyc = 0; ticks = 0;
        while (mode == 3'd4 && cyc < 2000) begin
            cyc++;
            ticks += int'(sub_tick);
            if (cyc == 2 && inj == 1) begin
                cc_wr = 1; cc_div = 2'b01; cc_sub_xtal = 1;
                pm_wr = 1; pm_osc_off = 1; sleep_req = 1; halt_req = 1;
            end
            if (cyc == 2 && inj == 2) wake_irq = 1;
            @(negedge clk);
            pm_wr = 0; cc_wr = 0; halt_req = 0; sleep_req = 0; wake_irq = 0;
        end
    endtask

    task automatic t_reset;
        chk("R1 mode", mode, 0);
        chk("R1 main_osc_en", main_osc_en, 1);
        chk("R1 ready", cpu_clk_ready, 1);
        chk("R1 clk_on_sub", clk_on_sub, 0);
        chk("R1 osc_off", osc_off, 0);
        chk("R1 div_sel", div_sel, 0);
        chk("R1 sub_xtal", sub_xtal, 0);
    endtask

    task automatic t_cfg_write;
        pulse_in(0, 0, 1, 2'b10, 1, 0, 0, 0);
        chk("R5 div write", div_sel, 2);
        chk("R5 xtal write", sub_xtal, 1);
        pulse_in(0, 0, 1, 2'b10, 0, 0, 0, 0);
        chk("R5 ring select", sub_xtal, 0);
    endtask

    task automatic t_halt_main;
        pulse_in(0, 0, 0, 2'b00, 0, 1, 0, 0);
        chk("R6 halt mode", mode, 2);
        chk("R6 halt osc kept", main_osc_en, 1);
        pulse_in(1, 1, 1, 2'b11, 1, 0, 0, 0);
        pulse_in(0, 0, 0, 2'b00, 0, 0, 0, 1);
        chk("R6 halt return mode", mode, 0);
        chk("R10 halt wake pulse", cpu_wake, 1);
        chk("R6 div kept", div_sel, 2);
        chk("R6 xtal kept", sub_xtal, 0);
        chk("R6 osc_off kept", osc_off, 0);
        @(negedge clk);
        chk("R10 pulse one cycle", cpu_wake, 0);
    endtask

    task automatic t_to_sub;
        pulse_in(1, 1, 0, 2'b00, 0, 0, 0, 0);
        chk("R8 sub mode", mode, 1);
        chk("R8 osc off", main_osc_en, 0);
        chk("R8 clk_on_sub", clk_on_sub, 1);
    endtask

    task automatic t_halt_sub;
        pulse_in(0, 0, 0, 2'b00, 0, 1, 0, 0);
        chk("R6 halt from sub osc", main_osc_en, 0);
        pulse_in(0, 0, 0, 2'b00, 0, 0, 0, 1);
        chk("R6 return to sub", mode, 1);
        chk("R6 sub flag kept", clk_on_sub, 1);
    endtask

    task automatic t_sleep_sub_wake;
        pulse_in(0, 0, 1, 2'b11, 0, 0, 0, 0);
        pulse_in(0, 0, 0, 2'b00, 0, 0, 1, 0);
        chk("R2 sleep mode", mode, 3);
        chk("R2 sleep osc", main_osc_en, 0);
        chk("R2 sleep ready", cpu_clk_ready, 0);
        pulse_in(0, 0, 0, 2'b00, 0, 0, 0, 1);
        chk("R4 wake to sub", mode, 1);
        chk("R4 clk_on_sub", clk_on_sub, 1);
        chk("R4 osc stays off", main_osc_en, 0);
        chk("R4 div unchanged", div_sel, 3);
        chk("R10 wake pulse sub", cpu_wake, 1);
    endtask

    task automatic t_sub_to_main;
        int cyc, ticks;
        pulse_in(1, 0, 0, 2'b00, 0, 0, 0, 0);
        chk("R7 enters stab", mode, 4);
        chk("R7 osc started", main_osc_en, 1);
        measure_stab(1, cyc, ticks);
        chk("R7 stab length", cyc, 5);
        chk("R7 main mode", mode, 0);
        chk("R7 div preserved", div_sel, 3);
        chk("R7 no wake pulse", cpu_wake, 0);
        chk("R9 div write ignored", div_sel, 3);
        chk("R9 xtal write ignored", sub_xtal, 0);
        chk("R9 osc_off write ignored", osc_off, 0);
    endtask

    task automatic t_sleep_main_wake;
        int cyc, ticks;
        pulse_in(0, 0, 1, 2'b01, 1, 0, 0, 0);
        pulse_in(0, 0, 0, 2'b00, 0, 0, 1, 0);
        chk("R2 sleep from main", main_osc_en, 0);
        pulse_in(0, 0, 0, 2'b00, 0, 0, 0, 1);
        chk("R3 stab after wake", mode, 4);
        chk("R3 ready low", cpu_clk_ready, 0);
        measure_stab(2, cyc, ticks);
        chk("R10 irq does not shorten", cyc, 5);
        chk("R3 main mode", mode, 0);
        chk("R3 clk_on_sub", clk_on_sub, 0);
        chk("R3 div forced", div_sel, 0);
        chk("R3 xtal kept", sub_xtal, 1);
        chk("R10 wake pulse main", cpu_wake, 1);
    endtask

    task automatic t_tick_pattern;
        int cyc, ticks;
        tick_period = 3;
        stab_len = 16'd4;
        pulse_in(1, 1, 0, 2'b00, 0, 0, 0, 0);
        pulse_in(1, 0, 0, 2'b00, 0, 0, 0, 0);
        measure_stab(0, cyc, ticks);
        chk("R11 ticks counted", ticks, 4);
        chk("R11 sparse stretches", int'(cyc >= 10), 1);
        stab_len = 16'd0;
        pulse_in(1, 1, 0, 2'b00, 0, 0, 0, 0);
        pulse_in(1, 0, 0, 2'b00, 0, 0, 0, 0);
        measure_stab(0, cyc, ticks);
        chk("R11 zero length as one", ticks, 1);
        chk("R11 back to main", mode, 0);
        tick_period = 1;
        stab_len = 16'd5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_write();
        t_halt_main();
        t_to_sub();
        t_halt_sub();
        t_sleep_sub_wake();
        t_sub_to_main();
        t_sleep_main_wake();
        t_tick_pattern();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done_flag) begin
            done_flag = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule